// File: doc/BRIEF.md
# Nested Prioritized Interrupt Selector

This block holds a pending flag for each of up to 32 interrupt sources and, every cycle, picks the single most urgent source that may be taken. Urgency is set per source by two programmable fields. The group field decides whether a request may interrupt the handler that is already running. The sub field only breaks ties among requests that are waiting at the same time. A smaller value is always more urgent.

A request is taken only when all of the following hold:
- global interrupts are not disabled,
- its own enable is set,
- the threshold mask does not block it,
- its group is strictly more urgent than the group of the running handler.

A blocked request stays pending until it becomes eligible.

Taking a request does three things in the same clock edge:
- it raises a one-cycle take strobe with the source number and group,
- it clears that source's pending flag,
- it pushes the group onto an internal nesting stack.

The top of the stack is the active priority. A handler-exit strobe pops the stack and so restores the priority of the interrupted handler. Vector fetch and context saving belong to the surrounding core.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After synchronous reset, all pending flags are 0, `take` is 0, `nest_lvl` is 0 and `act_valid` is 0.
- R2: A one-cycle pulse on `irq_req[i]` sets pending bit i at the next clock edge. If the source is eligible, `take` is 1 for one cycle, starting at the second edge after the pulse. In that cycle `take_id` = i and `take_grp` is the group field of source i.
- R3: Source i's group is `grp_pri[i*GW +: GW]` and its sub field is `sub_pri[i*SW +: SW]`. Among eligible sources, the one with the numerically lowest group is taken first.
- R4: Among eligible sources with equal group, the one with the numerically lowest sub field is taken first.
- R5: When both group and sub field tie, the lowest source index is taken first.
- R6: While a handler is active, a source is eligible only if its group is strictly lower than `act_grp`. An equal or higher group is not taken and stays pending. When no handler is active, any group is eligible.
- R7: When `mask_thr` is 0, no threshold masking applies. Otherwise, sources whose group is greater than or equal to `mask_thr` are not taken and stay pending.
- R8: While `glob_dis` is 1, or while `src_en[i]` is 0, source i is not taken. Its pending flag is kept, and it is taken once the block is lifted.
- R9: A take clears the pending bit of that source and pushes its group. `act_grp` then equals the taken group and `nest_lvl` increases by one.
- R10: A pulse on `hnd_exit` pops one level, restoring the previous `act_grp`, or `act_valid` = 0 when the stack becomes empty. No take happens in the exit cycle. An exit with an empty stack changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Request pulses, one bit per source |
| src_en | input | 32 | Per-source enable |
| grp_pri | input | 64 | Group field per source, GW bits each |
| sub_pri | input | 64 | Sub field per source, SW bits each |
| glob_dis | input | 1 | Global disable |
| mask_thr | input | 2 | Threshold, 0 = off |
| hnd_exit | input | 1 | Handler exit strobe |
| take | output | 1 | One-cycle take strobe |
| take_id | output | 5 | Taken source number |
| take_grp | output | 2 | Group of the taken source |
| pend | output | 32 | Pending flags |
| act_valid | output | 1 | A handler is active |
| act_grp | output | 2 | Group of the active handler |
| nest_lvl | output | 3 | Current nesting depth |

## Verification
The bench raises simultaneous requests that differ only in group, only in sub field, or not at all. A comparator that ranks on the wrong field, or that lets the highest index win a tie, would take the wrong source first.

It also targets preemption by an equal group. A design using a non-strict compare would nest a same-group handler and push `nest_lvl` up where it must stay.

Threshold, global disable and per-source enable are each checked twice: once while they block, to confirm the request stays pending, and once after release, to confirm it is taken then. A design that drops blocked requests would never produce the late take.

Nested exits are followed level by level, to catch a stack that restores the wrong priority or that underflows on an exit with nothing active.

// File: rtl/nia_pkg.sv
package nia_pkg;
  localparam int NIA_SRC_DEF   = 32;
  localparam int NIA_GW_DEF    = 2;
  localparam int NIA_SW_DEF    = 2;
  localparam int NIA_DEPTH_DEF = 4;

  function automatic int nia_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/nia_pick.sv
module nia_pick
  import nia_pkg::*;
#(
  parameter int N   = NIA_SRC_DEF,
  parameter int GW  = NIA_GW_DEF,
  parameter int SW  = NIA_SW_DEF,
  localparam int IDW = nia_bits(N),
  localparam int KW  = GW + SW
) (
  input  logic [N-1:0]    elig,
  input  logic [N*GW-1:0] grp_flat,
  input  logic [N*SW-1:0] sub_flat,
  output logic            win_valid,
  output logic [IDW-1:0]  win_id,
  output logic [GW-1:0]   win_grp
);
  logic [KW-1:0] key [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_key
      assign key[g] = {grp_flat[g*GW +: GW], sub_flat[g*SW +: SW]};
    end
  endgenerate

  logic [KW-1:0] best;

  // Strict compare keeps the lowest index on a full tie.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    best      = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!win_valid || key[i] < best)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        best      = key[i];
      end
    end
    win_grp = best[KW-1:SW];
  end
endmodule

// File: rtl/nia_nest_stack.sv
module nia_nest_stack
  import nia_pkg::*;
#(
  parameter int DEPTH = NIA_DEPTH_DEF,
  parameter int W     = NIA_GW_DEF,
  localparam int PW   = nia_bits(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_val,
  input  logic          pop,
  output logic [W-1:0]  top,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] top_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign top_idx = PW'(cnt - CW'(1));
  assign top     = empty ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[PW'(cnt)] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push && !full) cnt <= cnt + CW'(1);
    else if (pop && !empty) cnt <= cnt - CW'(1);
  end

  AST_STK_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R10
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> cnt == $past(cnt) + CW'(1)); // R9
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !empty) |=> cnt == $past(cnt) - CW'(1)); // R10
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import nia_pkg::*;
#(
  parameter int N     = NIA_SRC_DEF,
  parameter int GW    = NIA_GW_DEF,
  parameter int SW    = NIA_SW_DEF,
  parameter int DEPTH = NIA_DEPTH_DEF,
  localparam int IDW  = nia_bits(N),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    irq_req,
  input  logic [N-1:0]    src_en,
  input  logic [N*GW-1:0] grp_pri,
  input  logic [N*SW-1:0] sub_pri,
  input  logic            glob_dis,
  input  logic [GW-1:0]   mask_thr,
  input  logic            hnd_exit,
  output logic            take,
  output logic [IDW-1:0]  take_id,
  output logic [GW-1:0]   take_grp,
  output logic [N-1:0]    pend,
  output logic            act_valid,
  output logic [GW-1:0]   act_grp,
  output logic [CW-1:0]   nest_lvl
);
  logic [N-1:0]   pend_q, elig, clr;
  logic           win_valid, stk_empty, stk_full;
  logic [IDW-1:0] win_id;
  logic [GW-1:0]  win_grp, stk_top;
  logic           take_q;
  logic [IDW-1:0] take_id_q;
  logic [GW-1:0]  take_grp_q;

  // Per-source eligibility.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_elig
      logic [GW-1:0] grp_g;
      logic          thr_ok, pre_ok;
      assign grp_g  = grp_pri[g*GW +: GW];
      assign thr_ok = (mask_thr == '0) || (grp_g < mask_thr);
      assign pre_ok = stk_empty || (grp_g < stk_top);
      assign elig[g] = pend_q[g] & src_en[g] & ~glob_dis & thr_ok & pre_ok
                       & ~stk_full & ~hnd_exit;
    end
  endgenerate

  nia_pick #(.N(N), .GW(GW), .SW(SW)) u_pick (
    .elig      (elig),
    .grp_flat  (grp_pri),
    .sub_flat  (sub_pri),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_grp   (win_grp)
  );

  nia_nest_stack #(.DEPTH(DEPTH), .W(GW)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (win_valid),
    .push_val (win_grp),
    .pop      (hnd_exit),
    .top      (stk_top),
    .cnt      (nest_lvl),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  always_comb begin
    clr = '0;
    if (win_valid) clr[win_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      take_q     <= 1'b0;
      take_id_q  <= '0;
      take_grp_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | irq_req;
      take_q <= win_valid;
      if (win_valid) begin
        take_id_q  <= win_id;
        take_grp_q <= win_grp;
      end
    end
  end

  assign take      = take_q;
  assign take_id   = take_id_q;
  assign take_grp  = take_grp_q;
  assign pend      = pend_q;
  assign act_valid = ~stk_empty;
  assign act_grp   = stk_top;

  AST_TAKE_WAS_PENDING: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (($past(pend_q) >> take_id_q) & N'(1)) != '0); // R9
  AST_TAKE_NOT_DISABLED: assert property (@(posedge clk) disable iff (rst)
    take_q |-> !$past(glob_dis)); // R8
  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (rst)
    (take_q && $past(act_valid)) |-> take_grp_q < $past(act_grp)); // R6
  AST_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    (take_q && $past(mask_thr) != '0) |-> take_grp_q < $past(mask_thr)); // R7
  AST_NO_TAKE_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
    take_q |-> !$past(hnd_exit)); // R10
  AST_TAKE_SETS_ACT: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (act_valid && act_grp == take_grp_q)); // R9
endmodule

// File: tb/nest_irq_arbiter_tb.sv
module nest_irq_arbiter_tb;
  localparam int N = 32, GW = 2, SW = 2, DEPTH = 4;

  logic          clk = 1'b0, rst = 1'b1;
  logic [N-1:0]  irq_req = '0, src_en = '1;
  logic [N*GW-1:0] grp_pri;
  logic [N*SW-1:0] sub_pri;
  logic          glob_dis = 1'b0, hnd_exit = 1'b0;
  logic [GW-1:0] mask_thr = '0;
  logic          take, act_valid;
  logic [4:0]    take_id;
  logic [GW-1:0] take_grp, act_grp;
  logic [N-1:0]  pend;
  logic [2:0]    nest_lvl;

  logic [GW-1:0] grp_cfg [N];
  logic [SW-1:0] sub_cfg [N];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grp_pri[i*GW +: GW] = grp_cfg[i];
      sub_pri[i*SW +: SW] = sub_cfg[i];
    end
  end

  nest_irq_arbiter u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .src_en(src_en),
    .grp_pri(grp_pri), .sub_pri(sub_pri), .glob_dis(glob_dis),
    .mask_thr(mask_thr), .hnd_exit(hnd_exit), .take(take),
    .take_id(take_id), .take_grp(take_grp), .pend(pend),
    .act_valid(act_valid), .act_grp(act_grp), .nest_lvl(nest_lvl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_req = m;
    step();
    irq_req = '0;
  endtask

  task automatic do_exit();
    hnd_exit = 1'b1;
    step();
    hnd_exit = 1'b0;
  endtask

  task automatic expect_take(input string req, input int id, input int grp);
    check({req, " take"}, 32'(take), 32'd1);
    check({req, " id"}, 32'(take_id), 32'(id));
    check({req, " grp"}, 32'(take_grp), 32'(grp));
  endtask

  task automatic t_reset();
    check("R1 take", 32'(take), 0);
    check("R1 pend", pend, 0);
    check("R1 lvl", 32'(nest_lvl), 0);
    check("R1 act_valid", 32'(act_valid), 0);
  endtask

  task automatic t_basic();
    grp_cfg[5] = 2;
    pulse(32'h1 << 5);
    check("R2 pend set", 32'(pend[5]), 1);
    step();
    expect_take("R2", 5, 2);
    check("R9 pend cleared", 32'(pend[5]), 0);
    check("R9 act_grp", 32'(act_grp), 2);
    check("R9 lvl", 32'(nest_lvl), 1);
    step();
    check("R2 strobe one cycle", 32'(take), 0);
    do_exit();
    check("R10 lvl", 32'(nest_lvl), 0);
    check("R10 act_valid", 32'(act_valid), 0);
  endtask

  task automatic t_group();
    grp_cfg[3] = 2; grp_cfg[7] = 1;
    pulse((32'h1 << 3) | (32'h1 << 7));
    step();
    expect_take("R3", 7, 1);
    step();
    check("R6 lower urgency no take", 32'(take), 0);
    check("R6 stays pending", 32'(pend[3]), 1);
    do_exit();
    check("R10 no take in exit cycle", 32'(take), 0);
    step();
    expect_take("R3 second", 3, 2);
    do_exit();
  endtask

  task automatic t_sub();
    grp_cfg[4] = 1; sub_cfg[4] = 3; grp_cfg[9] = 1; sub_cfg[9] = 0;
    pulse((32'h1 << 4) | (32'h1 << 9));
    step();
    expect_take("R4", 9, 1);
    do_exit();
    step();
    expect_take("R4 second", 4, 1);
    do_exit();
  endtask

  task automatic t_tie();
    grp_cfg[10] = 1; sub_cfg[10] = 1; grp_cfg[12] = 1; sub_cfg[12] = 1;
    pulse((32'h1 << 10) | (32'h1 << 12));
    step();
    expect_take("R5", 10, 1);
    do_exit();
    step();
    expect_take("R5 second", 12, 1);
    do_exit();
  endtask

  task automatic t_nest();
    grp_cfg[1] = 3; grp_cfg[2] = 1; grp_cfg[6] = 1;
    pulse(32'h1 << 1);
    step();
    expect_take("R6 idle any", 1, 3);
    pulse(32'h1 << 2);
    step();
    expect_take("R6 preempt", 2, 1);
    check("R9 lvl2", 32'(nest_lvl), 2);
    pulse(32'h1 << 6);
    step();
    check("R6 equal no preempt", 32'(take), 0);
    check("R6 equal lvl", 32'(nest_lvl), 2);
    do_exit();
    check("R10 restored grp", 32'(act_grp), 3);
    check("R10 restored lvl", 32'(nest_lvl), 1);
    step();
    expect_take("R6 after pop", 6, 1);
    do_exit();
    do_exit();
    check("R10 unwound", 32'(nest_lvl), 0);
  endtask

  task automatic t_thr();
    grp_cfg[11] = 2; grp_cfg[13] = 1;
    mask_thr = 2;
    pulse((32'h1 << 11) | (32'h1 << 13));
    step();
    expect_take("R7 below thr", 13, 1);
    do_exit();
    step();
    check("R7 at thr blocked", 32'(take), 0);
    check("R7 kept pending", 32'(pend[11]), 1);
    mask_thr = 0;
    step();
    expect_take("R7 thr off", 11, 2);
    do_exit();
  endtask

  task automatic t_disable();
    grp_cfg[20] = 0;
    glob_dis = 1'b1;
    pulse(32'h1 << 20);
    step(); step();
    check("R8 gdis no take", 32'(take), 0);
    check("R8 gdis pending", 32'(pend[20]), 1);
    glob_dis = 1'b0;
    step();
    expect_take("R8 gdis released", 20, 0);
    do_exit();
    grp_cfg[21] = 1;
    src_en = ~(32'h1 << 21);
    pulse(32'h1 << 21);
    step();
    check("R8 en no take", 32'(take), 0);
    check("R8 en pending", 32'(pend[21]), 1);
    src_en = '1;
    step();
    expect_take("R8 en released", 21, 1);
    do_exit();
  endtask

  task automatic t_empty_exit();
    do_exit();
    check("R10 empty exit lvl", 32'(nest_lvl), 0);
    check("R10 empty exit act", 32'(act_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      grp_cfg[i] = 3;
      sub_cfg[i] = 3;
    end
    step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_basic();
    t_group();
    t_sub();
    t_tie();
    t_nest();
    t_thr();
    t_disable();
    t_empty_exit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule